// File: doc/BRIEF.md
# Multi-source initial reset controller

This block gathers every reason a small low-power microcontroller may need to restart. It merges them into one system reset line, clocked from the 32 kHz oscillator domain. The four causes are a power-up event, an active-high reset pin, a chord of key lines held high together, and a request from the watchdog counter. The power-up path keeps the system in reset until the oscillator reports that it is running. The pin and chord paths pass through a time-qualified noise rejector, so only an assertion that is held long enough restarts the system.

A two-bit selection input chooses which key lines form the chord: none, two, three or four lines. It is sampled only while the system is in reset, so firmware activity cannot alter it. A small cause register reports which source produced the most recent reset. All reset removal is synchronous to the clock.

Top module: `rst_merge_ctrl`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is high and `cause_o` is 0. After `por_i` falls, `sys_rst_o` stays high up to and including the first rising edge at which `osc_ok_i` is sampled high.
- R2: The pin source becomes active only after `rst_pin_i` has been sampled high on QUAL_CYC consecutive rising edges (default 160). `sys_rst_o` rises just after the QUAL_CYC-th edge. A shorter run is rejected, and a low sample restarts the count from zero.
- R3: An active pin or chord source stays active while its condition stays high. It drops just after the first edge that samples the condition low.
- R4: The chord setting is encoded as 0 = chord disabled, 1 = `keys_i[1:0]` all high, 2 = `keys_i[2:0]` all high, 3 = `keys_i[3:0]` all high. A chord that matches passes through the same filter as in R2.
- R5: A chord with any required key low, including a single key high alone, causes no reset however long it is held.
- R6: A watchdog request sampled high on an edge makes `sys_rst_o` high for exactly WDT_CYC cycles (default 4) after the last such edge, with no filtering.
- R7: `sys_rst_o` is the OR of all active sources. `cause_o` updates on the edge at which a source becomes active: 1 for pin, 2 for chord, 3 for watchdog. If several sources activate on the same edge, the priority is watchdog, then chord, then pin.
- R8: The chord setting takes the value of `chord_sel_i` on each edge at which `sys_rst_o` is high. A change to `chord_sel_i` while `sys_rst_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz system clock |
| por_i | input | 1 | Power-up indication, active high, asynchronous |
| osc_ok_i | input | 1 | Oscillator running status |
| rst_pin_i | input | 1 | External reset pin, active high |
| keys_i | input | 4 | Key input lines used for the chord |
| chord_sel_i | input | 2 | Chord setting, encoded as in R4 |
| wdt_req_i | input | 1 | Watchdog reset request |
| sys_rst_o | output | 1 | System initial reset, active high |
| cause_o | output | 2 | Cause of the latest reset, encoded as in R1 and R7 |

## Verification
The watchdog request can land on the same edge at which a filter completes its qualification. The bench holds the pin high for QUAL_CYC-1 edges and raises the watchdog request for the QUAL_CYC-th edge. It then expects cause 3 and a reset that lasts while either source is still active. A second collision drives the pin and a matching chord from the same cycle and expects cause 2. Long random stretches of pin, key, watchdog and power-up activity are compared each cycle against a bench model.

// File: rtl/rst_merge_pkg.sv
package rst_merge_pkg;

  typedef enum logic [1:0] {
    CAUSE_PWR = 2'd0,
    CAUSE_PIN = 2'd1,
    CAUSE_KEY = 2'd2,
    CAUSE_WDT = 2'd3
  } cause_e;

  // Required key lines for a chord setting: setting s needs the low s+1 lines.
  function automatic logic [3:0] chord_mask(input logic [1:0] sel);
    logic [4:0] ones;
    ones = (5'd1 << ({3'd0, sel} + 5'd1)) - 5'd1;
    return (sel == 2'd0) ? 4'd0 : ones[3:0];
  endfunction

  function automatic logic chord_hit(input logic [3:0] keys, input logic [1:0] sel);
    return (sel != 2'd0) && ((keys & chord_mask(sel)) == chord_mask(sel));
  endfunction

endpackage

// File: rtl/rst_hold_filter.sv
module rst_hold_filter #(
  parameter int unsigned QUAL = 160
) (
  input  logic clk,
  input  logic arst,
  input  logic cond_i,
  output logic fire_o,
  output logic act_o
);
  localparam int unsigned CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                cnt_q <= '0;
    else if (!cond_i)        cnt_q <= '0;
    else if (cnt_q != FULL)  cnt_q <= cnt_q + 1'b1;
  end

  // fire_o marks the edge on which act_o will rise
  assign fire_o = cond_i && (cnt_q == LAST);
  assign act_o  = (cnt_q == FULL);
endmodule

// File: rtl/rst_wdt_stretch.sv
module rst_wdt_stretch #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic req_i,
  output logic act_o
);
  localparam int unsigned WW = $clog2(HOLD + 1);
  localparam logic [WW-1:0] LOAD = WW'(HOLD);

  logic [WW-1:0] left_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                left_q <= '0;
    else if (req_i)          left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign act_o = (left_q != '0);
endmodule

// File: rtl/rst_merge_ctrl.sv
module rst_merge_ctrl
  import rst_merge_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 160,
  parameter int unsigned WDT_CYC  = 4
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       osc_ok_i,
  input  logic       rst_pin_i,
  input  logic [3:0] keys_i,
  input  logic [1:0] chord_sel_i,
  input  logic       wdt_req_i,
  output logic       sys_rst_o,
  output logic [1:0] cause_o
);
  localparam int unsigned NSRC = 2;  // index 0: pin, index 1: chord

  logic            pwr_hold;
  logic [1:0]      sel_q;
  logic            chord_cond;
  logic [NSRC-1:0] src_cond, src_fire, src_act;
  logic            pin_act, chord_act, pin_fire, chord_fire, wdt_act;
  cause_e          cause_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)         pwr_hold <= 1'b1;
    else if (osc_ok_i) pwr_hold <= 1'b0;
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)          sel_q <= 2'd0;
    else if (sys_rst_o) sel_q <= chord_sel_i;
  end

  assign chord_cond = chord_hit(keys_i, sel_q);
  assign src_cond   = {chord_cond, rst_pin_i};

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_flt
      rst_hold_filter #(.QUAL(QUAL_CYC)) u_flt (
        .clk    (clk),
        .arst   (por_i),
        .cond_i (src_cond[g]),
        .fire_o (src_fire[g]),
        .act_o  (src_act[g])
      );
    end
  endgenerate

  assign pin_act    = src_act[0];
  assign chord_act  = src_act[1];
  assign pin_fire   = src_fire[0];
  assign chord_fire = src_fire[1];

  rst_wdt_stretch #(.HOLD(WDT_CYC)) u_wdt (
    .clk   (clk),
    .arst  (por_i),
    .req_i (wdt_req_i),
    .act_o (wdt_act)
  );

  assign sys_rst_o = pwr_hold | pin_act | chord_act | wdt_act;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)           cause_q <= CAUSE_PWR;
    else if (wdt_req_i)  cause_q <= CAUSE_WDT;
    else if (chord_fire) cause_q <= CAUSE_KEY;
    else if (pin_fire)   cause_q <= CAUSE_PIN;
  end

  assign cause_o = cause_q;
endmodule

module rst_merge_chk (
  input logic       clk,
  input logic       por_i,
  input logic       osc_ok_i,
  input logic       rst_pin_i,
  input logic       wdt_req_i,
  input logic       pwr_hold,
  input logic       pin_act,
  input logic       chord_act,
  input logic       chord_cond,
  input logic [1:0] sel_q,
  input logic       sys_rst_o,
  input logic [1:0] cause_o
);
  p_por_hold_r1: assert property (@(posedge clk) disable iff (por_i)
    (pwr_hold && !osc_ok_i) |=> pwr_hold);

  p_pin_qual_r2: assert property (@(posedge clk) disable iff (por_i)
    $rose(pin_act) |-> $past(rst_pin_i));

  p_pin_release_r3: assert property (@(posedge clk) disable iff (por_i)
    !rst_pin_i |=> !pin_act);

  p_chord_qual_r4: assert property (@(posedge clk) disable iff (por_i)
    $rose(chord_act) |-> $past(chord_cond));

  p_partial_r5: assert property (@(posedge clk) disable iff (por_i)
    !chord_cond |=> !chord_act);

  p_wdt_hold_r6: assert property (@(posedge clk) disable iff (por_i)
    wdt_req_i |=> sys_rst_o);

  p_cause_wdt_r7: assert property (@(posedge clk) disable iff (por_i)
    wdt_req_i |=> (cause_o == 2'd3));

  p_sel_frozen_r8: assert property (@(posedge clk) disable iff (por_i)
    !sys_rst_o |=> $stable(sel_q));
endmodule

bind rst_merge_ctrl rst_merge_chk u_chk (
  .clk        (clk),
  .por_i      (por_i),
  .osc_ok_i   (osc_ok_i),
  .rst_pin_i  (rst_pin_i),
  .wdt_req_i  (wdt_req_i),
  .pwr_hold   (pwr_hold),
  .pin_act    (pin_act),
  .chord_act  (chord_act),
  .chord_cond (chord_cond),
  .sel_q      (sel_q),
  .sys_rst_o  (sys_rst_o),
  .cause_o    (cause_o)
);

// File: tb/sim_rst_merge_ctrl.sv
`timescale 1ns/1ps
module sim_rst_merge_ctrl;
  localparam int Q = 160;
  localparam int W = 4;

  logic clk = 1'b0;
  logic por_i, osc_ok_i, rst_pin_i, wdt_req_i;
  logic [3:0] keys_i;
  logic [1:0] chord_sel_i;
  logic sys_rst_o;
  logic [1:0] cause_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  rst_merge_ctrl #(.QUAL_CYC(Q), .WDT_CYC(W)) u0 (
    .clk(clk), .por_i(por_i), .osc_ok_i(osc_ok_i), .rst_pin_i(rst_pin_i),
    .keys_i(keys_i), .chord_sel_i(chord_sel_i), .wdt_req_i(wdt_req_i),
    .sys_rst_o(sys_rst_o), .cause_o(cause_o));

  // ---------------- bench model ----------------
  bit m_pwr = 1;
  int m_pc = 0, m_kc = 0, m_wc = 0;
  int m_cause = 0;
  logic [1:0] m_sel = 0;

  function automatic bit exp_chord(logic [3:0] k, logic [1:0] s);
    case (s)
      2'd1:    return k[0] & k[1];
      2'd2:    return k[0] & k[1] & k[2];
      2'd3:    return k[0] & k[1] & k[2] & k[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_rst();
    return m_pwr || (m_pc == Q) || (m_kc == Q) || (m_wc != 0);
  endfunction

  always @(posedge clk) begin
    if (por_i) begin
      m_pwr = 1; m_pc = 0; m_kc = 0; m_wc = 0; m_cause = 0; m_sel = 0;
    end else begin
      bit old_rst, ch, pf, kf;
      old_rst = m_rst();
      ch = exp_chord(keys_i, m_sel);
      pf = rst_pin_i && (m_pc == Q - 1);
      kf = ch && (m_kc == Q - 1);
      m_pc = rst_pin_i ? ((m_pc < Q) ? m_pc + 1 : Q) : 0;
      m_kc = ch ? ((m_kc < Q) ? m_kc + 1 : Q) : 0;
      m_wc = wdt_req_i ? W : ((m_wc > 0) ? m_wc - 1 : 0);
      if (wdt_req_i) m_cause = 3;
      else if (kf)   m_cause = 2;
      else if (pf)   m_cause = 1;
      if (old_rst)  m_sel = chord_sel_i;
      if (osc_ok_i) m_pwr = 0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: edge, then compare at the falling edge against the model
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(cur_req, int'(sys_rst_o), int'(m_rst()), "model sys_rst");
      chk(cur_req, int'(cause_o), m_cause, "model cause");
    end
  endtask

  // watchdog
  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    por_i = 1; osc_ok_i = 0; rst_pin_i = 0; wdt_req_i = 0; keys_i = 0; chord_sel_i = 2'd3;
    @(negedge clk);
    tick(3);
    chk("R1", sys_rst_o, 1, "reset during por");
    chk("R1", cause_o, 0, "cause during por");
    por_i = 0;
    tick(5);
    chk("R1", sys_rst_o, 1, "hold before osc ok");
    osc_ok_i = 1;
    tick(1);
    chk("R1", sys_rst_o, 0, "release after osc ok");

    // R2: short run rejected, restart, full run accepted
    cur_req = "R2";
    rst_pin_i = 1; tick(Q - 1);
    chk("R2", sys_rst_o, 0, "pin Q-1 rejected");
    rst_pin_i = 0; tick(1);
    rst_pin_i = 1; tick(Q - 1);
    chk("R2", sys_rst_o, 0, "pin restart rejected");
    tick(1);
    chk("R2", sys_rst_o, 1, "pin Q accepted");
    chk("R2", cause_o, 1, "pin cause");
    cur_req = "R3";
    tick(10);
    chk("R3", sys_rst_o, 1, "pin held");
    rst_pin_i = 0; tick(1);
    chk("R3", sys_rst_o, 0, "pin release next edge");

    // R5: partial chord under setting 3
    cur_req = "R5";
    keys_i = 4'b0111; tick(Q + 5);
    chk("R5", sys_rst_o, 0, "partial chord ignored");
    keys_i = 4'b0001; tick(Q + 5);
    chk("R5", sys_rst_o, 0, "single key ignored");

    // R4: full chord, setting 3
    cur_req = "R4";
    keys_i = 4'b1111; tick(Q);
    chk("R4", sys_rst_o, 1, "four-key chord");
    chk("R4", cause_o, 2, "chord cause");
    chord_sel_i = 2'd1; tick(1);      // loaded while in reset
    keys_i = 4'b0000; tick(1);
    chk("R3", sys_rst_o, 0, "chord release");

    // R8: change while running is ignored; setting 1 still used
    cur_req = "R8";
    chord_sel_i = 2'd3; tick(2);
    keys_i = 4'b0011; tick(Q);
    chk("R8", sys_rst_o, 1, "sel change in run ignored");
    chord_sel_i = 2'd0; tick(1);       // load setting 0 (disabled)
    keys_i = 4'b0000; tick(1);
    cur_req = "R4";
    keys_i = 4'b1111; tick(Q + 5);
    chk("R4", sys_rst_o, 0, "setting 0 disables chord");
    keys_i = 4'b0000; tick(1);

    // R6: watchdog pulse stretch
    cur_req = "R6";
    wdt_req_i = 1; tick(1);
    wdt_req_i = 0;
    chk("R6", cause_o, 3, "wdt cause");
    for (int i = 0; i < W; i++) begin
      chk("R6", sys_rst_o, (i < W) ? 1 : 0, "wdt stretch");
      tick(1);
    end
    chk("R6", sys_rst_o, 0, "wdt end");

    // R7: watchdog on the pin qualifying edge
    cur_req = "R7";
    chord_sel_i = 2'd1;
    rst_pin_i = 1; tick(Q - 1);
    wdt_req_i = 1; tick(1);
    chk("R7", cause_o, 3, "wdt wins over pin");
    chk("R7", sys_rst_o, 1, "collision reset");
    wdt_req_i = 0; rst_pin_i = 0; tick(1);
    chk("R7", sys_rst_o, 1, "wdt keeps reset after pin drop");
    tick(W);
    chk("R7", sys_rst_o, 0, "collision over");
    // chord and pin on the same edge
    rst_pin_i = 1; keys_i = 4'b0011; tick(Q);
    chk("R7", cause_o, 2, "chord wins over pin");
    rst_pin_i = 0; keys_i = 0; tick(1);

    // random phase
    cur_req = "R7";
    for (int ep = 0; ep < 400; ep++) begin
      int len, r;
      r = int'($urandom_range(0, 9));
      case (r)
        0: len = Q - 1;
        1: len = Q;
        2: len = Q + int'($urandom_range(1, 20));
        default: len = int'($urandom_range(1, 40));
      endcase
      rst_pin_i   = ($urandom_range(0, 2) == 0);
      keys_i      = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) keys_i = 4'hF;
      chord_sel_i = 2'($urandom_range(0, 3));
      wdt_req_i   = ($urandom_range(0, 15) == 0);
      osc_ok_i    = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 60) == 0) begin
        por_i = 1; tick(2); por_i = 0;
      end
      tick(1);
      wdt_req_i = 0;
      tick(len);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule